// File: doc/BRIEF.md
# Per-Pixel Plane Source Selector

This block is one stage of a display scan-out path. It walks a frame in raster order and, for every pixel, issues reads to three memory planes. The first is an indexed plane with one byte per pixel. The second is a direct-colour plane with one 32-bit word per pixel. The third is a control plane, also one 32-bit word per pixel. Every line in every plane is 1024 pixels apart, whatever the active width. The read data for each plane comes back one cycle after its read strobe.

The index byte is forwarded to an external palette, which answers after a fixed latency. The direct word and the control code travel down a delay line of the same length. This keeps the palette answer and the direct colour aligned to the same pixel. A code of 0x03 in the top byte of the control word selects the direct colour; any other code selects the palette colour. An index-only mode skips the direct and control fetches and sends every pixel through the palette.

The sequencer has three states:
- `ST_IDLE` waits for a start pulse. The transition `go` (start while idle) latches the frame size and the mode, then enters `ST_SCAN`.
- `ST_SCAN` issues one pixel fetch per enabled cycle. The transition `last_fetch` (an enabled cycle at the final pixel) enters `ST_DRAIN`.
- `ST_DRAIN` waits for the pipeline to empty. The transition `flush` (the final pixel leaves the output register) returns to `ST_IDLE`.

Top module: `plane_mux_scan`

## Requirements
- R1: A start pulse sampled in `ST_IDLE` begins a frame at pixel (0,0) and latches `width_i`, `height_i` and `index_only_i`. A start pulse, or a change of these inputs, while a frame is in progress has no effect on that frame.
- R2: Fetches run in raster order (x fastest), at most one per cycle. A fetch strobe appears only in the cycle after an edge at which `enable_i` was high. With `enable_i` low, the scan pauses without skipping a pixel.
- R3: For pixel (x,y), the pixel offset is y*1024+x, for any active width. `idx_addr_o` equals the offset, and `dir_addr_o` and `ctl_addr_o` each equal 4 times the offset.
- R4: When bits 31:24 of the pixel's control word equal 0x03, `pix_rgb_o` equals bits 23:0 of the direct word (red 23:16, green 15:8, blue 7:0). Bits 31:24 of the direct word have no effect.
- R5: For any other control code, `pix_rgb_o` equals the palette colour returned for that pixel's index.
- R6: In index-only mode, `dir_rd_o` and `ctl_rd_o` stay low and every pixel takes its palette colour, whatever the control data.
- R7: `pal_idx_o` carries the pixel's index byte, with `pal_req_o` high, one cycle after its fetch strobe. The pixel appears on `pix_valid_o` exactly PAL_LAT+2 cycles after its fetch strobe. Each frame yields exactly width*height pixels.
- R8: `done_o` is a one-cycle pulse in the cycle after the last pixel of a frame. `busy_o` is low in that cycle, and a start pulse sampled at the end of that cycle begins the next frame.
- R9: During and right after reset, every strobe, `done_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Frame start pulse |
| enable_i | input | 1 | Allows one pixel fetch in this cycle |
| index_only_i | input | 1 | Palette-only mode, latched at start |
| width_i | input | 11 | Active width, 1..1024 |
| height_i | input | 10 | Active height, 1..768 |
| idx_rd_o | output | 1 | Indexed plane read strobe |
| idx_addr_o | output | 20 | Indexed plane byte address |
| dir_rd_o | output | 1 | Direct plane read strobe |
| dir_addr_o | output | 22 | Direct plane byte address |
| ctl_rd_o | output | 1 | Control plane read strobe |
| ctl_addr_o | output | 22 | Control plane byte address |
| idx_data_i | input | 8 | Index byte, one cycle after strobe |
| dir_data_i | input | 32 | Direct word, one cycle after strobe |
| ctl_data_i | input | 32 | Control word, one cycle after strobe |
| pal_req_o | output | 1 | Palette lookup request |
| pal_idx_o | output | 8 | Palette lookup index |
| pal_rgb_i | input | 24 | Palette colour, PAL_LAT cycles after request |
| pix_valid_o | output | 1 | Output pixel strobe |
| pix_rgb_o | output | 24 | Output pixel colour |
| done_o | output | 1 | Frame complete pulse |
| busy_o | output | 1 | Frame in progress |

## Verification
Two things can land in the same cycle. The first is the `done_o` pulse of one frame and the start pulse of the next. The test drives start in exactly the `done_o` cycle of an index-only frame. It then expects the next frame's first fetch at offset 0, with the direct and control strobes back on. The second is a start pulse that arrives while a frame is still fetching. The test sends one with a different width mid-frame, and the reference queues show whether the running frame kept its order and size.

// File: rtl/pmx_pkg.sv
package pmx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_DRAIN = 2'd2
    } scan_state_e;

    localparam logic [7:0] DIRECT_CODE = 8'h03;

    typedef struct packed {
        logic        last;
        logic        direct;
        logic [23:0] rgb;
    } pix_tag_t;

endpackage

// File: rtl/pmx_addr_gen.sv
module pmx_addr_gen
    import pmx_pkg::*;
#(
    parameter int PITCH = 1024,
    parameter int MAX_H = 768,
    parameter int X_W   = $clog2(PITCH + 1),
    parameter int Y_W   = $clog2(MAX_H + 1),
    parameter int OFS_W = $clog2(PITCH * MAX_H)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             enable_i,
    input  logic             index_only_i,
    input  logic [X_W-1:0]   width_i,
    input  logic [Y_W-1:0]   height_i,
    input  logic             flush_i,
    output logic             rd_o,
    output logic [OFS_W-1:0] ofs_o,
    output logic             last_o,
    output logic             idx_only_o,
    output logic             busy_o
);
    localparam int COL_W = $clog2(PITCH);

    scan_state_e    state_q, state_d;
    logic [X_W-1:0] w_q, x_q;
    logic [Y_W-1:0] h_q, y_q;
    logic           io_q, rd_q, last_q;
    logic [OFS_W-1:0] ofs_q;
    logic           go, fire, row_end, at_last;

    assign row_end = (x_q == w_q - X_W'(1));
    assign at_last = row_end && (y_q == h_q - Y_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        go      = 1'b0;
        fire    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                go = start_i;
                if (start_i) state_d = ST_SCAN;
            end
            ST_SCAN: begin
                fire = enable_i;
                if (enable_i && at_last) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (flush_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q    <= '0;
            h_q    <= '0;
            io_q   <= 1'b0;
            x_q    <= '0;
            y_q    <= '0;
            rd_q   <= 1'b0;
            last_q <= 1'b0;
            ofs_q  <= '0;
        end else begin
            rd_q   <= fire;
            last_q <= fire && at_last;
            if (go) begin
                w_q  <= width_i;
                h_q  <= height_i;
                io_q <= index_only_i;
                x_q  <= '0;
                y_q  <= '0;
            end else if (fire) begin
                ofs_q <= OFS_W'(y_q) * OFS_W'(PITCH) + OFS_W'(x_q);
                if (row_end) begin
                    x_q <= '0;
                    y_q <= y_q + Y_W'(1);
                end else begin
                    x_q <= x_q + X_W'(1);
                end
            end
        end
    end

    assign rd_o       = rd_q;
    assign ofs_o      = ofs_q;
    assign last_o     = last_q;
    assign idx_only_o = io_q;
    assign busy_o     = (state_q != ST_IDLE);

    AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q |-> (X_W'(ofs_q[COL_W-1:0]) < w_q)); // R3
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && start_i) |=> ($stable(w_q) && $stable(h_q))); // R1
    AST_FETCH_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q |-> $past(enable_i)); // R2

endmodule

// File: rtl/pmx_delay.sv
module pmx_delay
    import pmx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     v_i,
    input  pix_tag_t tag_i,
    output logic     v_o,
    output pix_tag_t tag_o
);
    generate
        if (DEPTH == 0) begin : g_pass
            assign v_o   = v_i;
            assign tag_o = tag_i;
        end else begin : g_chain
            logic     v_q   [DEPTH];
            pix_tag_t tag_q [DEPTH];
            for (genvar s = 0; s < DEPTH; s++) begin : g_stage
                always_ff @(posedge clk) begin
                    if (!rst_n) v_q[s] <= 1'b0;
                    else        v_q[s] <= (s == 0) ? v_i : v_q[(s == 0) ? 0 : s - 1];
                    tag_q[s] <= (s == 0) ? tag_i : tag_q[(s == 0) ? 0 : s - 1];
                end
            end
            assign v_o   = v_q[DEPTH-1];
            assign tag_o = tag_q[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/pmx_select.sv
module pmx_select
    import pmx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        v_i,
    input  pix_tag_t    tag_i,
    input  logic [23:0] pal_rgb_i,
    output logic        pix_valid_o,
    output logic [23:0] pix_rgb_o,
    output logic        pix_last_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_valid_o <= 1'b0;
            pix_last_o  <= 1'b0;
            pix_rgb_o   <= '0;
        end else begin
            pix_valid_o <= v_i;
            pix_last_o  <= v_i && tag_i.last;
            if (v_i) pix_rgb_o <= tag_i.direct ? tag_i.rgb : pal_rgb_i;
        end
    end

    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        pix_last_o |-> pix_valid_o); // R7
endmodule

// File: rtl/plane_mux_scan.sv
module plane_mux_scan
    import pmx_pkg::*;
#(
    parameter int PITCH   = 1024,
    parameter int MAX_H   = 768,
    parameter int PAL_LAT = 2,
    parameter int X_W     = $clog2(PITCH + 1),
    parameter int Y_W     = $clog2(MAX_H + 1),
    parameter int OFS_W   = $clog2(PITCH * MAX_H),
    parameter int WA_W    = OFS_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             enable_i,
    input  logic             index_only_i,
    input  logic [X_W-1:0]   width_i,
    input  logic [Y_W-1:0]   height_i,
    output logic             idx_rd_o,
    output logic [OFS_W-1:0] idx_addr_o,
    output logic             dir_rd_o,
    output logic [WA_W-1:0]  dir_addr_o,
    output logic             ctl_rd_o,
    output logic [WA_W-1:0]  ctl_addr_o,
    input  logic [7:0]       idx_data_i,
    input  logic [31:0]      dir_data_i,
    input  logic [31:0]      ctl_data_i,
    output logic             pal_req_o,
    output logic [7:0]       pal_idx_o,
    input  logic [23:0]      pal_rgb_i,
    output logic             pix_valid_o,
    output logic [23:0]      pix_rgb_o,
    output logic             done_o,
    output logic             busy_o
);
    logic             rd, last, io, flush, pix_last;
    logic [OFS_W-1:0] ofs;
    logic             mem_v_q, mem_last_q, done_q;
    pix_tag_t         mem_tag, dly_tag;
    logic             dly_v;

    pmx_addr_gen #(.PITCH(PITCH), .MAX_H(MAX_H), .X_W(X_W), .Y_W(Y_W), .OFS_W(OFS_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .enable_i(enable_i),
        .index_only_i(index_only_i), .width_i(width_i), .height_i(height_i),
        .flush_i(flush), .rd_o(rd), .ofs_o(ofs), .last_o(last),
        .idx_only_o(io), .busy_o(busy_o)
    );

    assign idx_rd_o   = rd;
    assign dir_rd_o   = rd && !io;
    assign ctl_rd_o   = rd && !io;
    assign idx_addr_o = ofs;
    assign dir_addr_o = {ofs, 2'b00};
    assign ctl_addr_o = {ofs, 2'b00};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_v_q    <= 1'b0;
            mem_last_q <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            mem_v_q    <= rd;
            mem_last_q <= last;
            done_q     <= flush;
        end
    end

    assign pal_req_o      = mem_v_q;
    assign pal_idx_o      = idx_data_i;
    assign mem_tag.last   = mem_last_q;
    assign mem_tag.direct = !io && (ctl_data_i[31:24] == DIRECT_CODE);
    assign mem_tag.rgb    = dir_data_i[23:0];

    pmx_delay #(.DEPTH(PAL_LAT)) u_dly (
        .clk(clk), .rst_n(rst_n), .v_i(mem_v_q), .tag_i(mem_tag),
        .v_o(dly_v), .tag_o(dly_tag)
    );

    pmx_select u_sel (
        .clk(clk), .rst_n(rst_n), .v_i(dly_v), .tag_i(dly_tag),
        .pal_rgb_i(pal_rgb_i), .pix_valid_o(pix_valid_o),
        .pix_rgb_o(pix_rgb_o), .pix_last_o(pix_last)
    );

    assign flush  = pix_valid_o && pix_last;
    assign done_o = done_q;

    AST_IDX_ONLY_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (io && busy_o) |-> (!dir_rd_o && !ctl_rd_o)); // R6
    AST_DONE_AFTER_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(pix_valid_o) && !busy_o)); // R8
    AST_DONE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_PAL_FOLLOWS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        idx_rd_o |=> pal_req_o); // R7
endmodule

// File: tb/test_plane_mux_scan.sv
module test_plane_mux_scan;
    localparam int PAL_LAT = 2;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        start_i = 1'b0, enable_i = 1'b0, index_only_i = 1'b0;
    logic [10:0] width_i = '0;
    logic [9:0]  height_i = '0;
    logic        idx_rd_o, dir_rd_o, ctl_rd_o, pal_req_o, pix_valid_o, done_o, busy_o;
    logic [19:0] idx_addr_o;
    logic [21:0] dir_addr_o, ctl_addr_o;
    logic [7:0]  idx_data_i = '0, pal_idx_o;
    logic [31:0] dir_data_i = '0, ctl_data_i = '0;
    logic [23:0] pal_rgb_i = '0, pal_s1 = '0, pix_rgb_o;

    int checks = 0, fails = 0, cyc = 0;
    int exp_ofs[$], exp_rgb[$], exp_io[$], exp_last[$], fetch_cyc[$], exp_pal[$];
    bit done_exp = 0, en_prev = 0, finished = 0;

    always #4 clk = ~clk;

    plane_mux_scan i_plane_mux_scan (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .enable_i(enable_i),
        .index_only_i(index_only_i), .width_i(width_i), .height_i(height_i),
        .idx_rd_o(idx_rd_o), .idx_addr_o(idx_addr_o), .dir_rd_o(dir_rd_o),
        .dir_addr_o(dir_addr_o), .ctl_rd_o(ctl_rd_o), .ctl_addr_o(ctl_addr_o),
        .idx_data_i(idx_data_i), .dir_data_i(dir_data_i), .ctl_data_i(ctl_data_i),
        .pal_req_o(pal_req_o), .pal_idx_o(pal_idx_o), .pal_rgb_i(pal_rgb_i),
        .pix_valid_o(pix_valid_o), .pix_rgb_o(pix_rgb_o), .done_o(done_o), .busy_o(busy_o)
    );

    function automatic logic [7:0] idx_fn(int o);
        return 8'(o * 13 + (o >> 10) * 5);
    endfunction
    function automatic logic [31:0] dir_fn(int o);
        return {8'(o ^ 8'hC3), 24'(o * 40503 + 24'h1234)};
    endfunction
    function automatic logic [31:0] ctl_fn(int o);
        logic [7:0] code;
        case (o % 3)
            0: code = 8'h03;
            1: code = 8'h02;
            default: code = 8'h83;
        endcase
        return {code, 24'(o * 7)};
    endfunction
    function automatic logic [23:0] pal_fn(logic [7:0] i);
        return {i ^ 8'h5A, i + 8'd7, ~i};
    endfunction

    // Memory planes answer one cycle after the strobe; palette answers PAL_LAT cycles later.
    always @(posedge clk) begin
        idx_data_i <= idx_fn(int'(idx_addr_o));
        dir_data_i <= dir_fn(int'(dir_addr_o >> 2));
        ctl_data_i <= ctl_fn(int'(ctl_addr_o >> 2));
        pal_s1     <= pal_fn(pal_idx_o);
        pal_rgb_i  <= pal_s1;
        cyc        <= cyc + 1;
    end

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            check(!idx_rd_o && !pix_valid_o && !done_o && !busy_o && !pal_req_o, "R9 reset outputs",
                  {idx_rd_o, pix_valid_o, done_o, busy_o, pal_req_o}, 0);
        end else if (!finished) begin
            check(done_o == done_exp, "R8 done pulse", done_o, done_exp);
            if (done_o) check(!busy_o, "R8 busy low at done", busy_o, 0);
            done_exp = 0;
            if (idx_rd_o) begin
                check(en_prev, "R2 fetch needs enable", en_prev, 1);
                if (exp_ofs.size() == 0) check(0, "R7 extra fetch", idx_addr_o, 0);
                else begin
                    int o, io;
                    o = exp_ofs.pop_front();
                    io = exp_io.pop_front();
                    check(idx_addr_o == 20'(o), "R2 R3 index address", idx_addr_o, o);
                    check(dir_addr_o == 22'(o * 4) && ctl_addr_o == 22'(o * 4), "R3 wide addresses",
                          dir_addr_o, o * 4);
                    check(dir_rd_o == !io && ctl_rd_o == !io, "R6 plane strobes",
                          {dir_rd_o, ctl_rd_o}, io ? 0 : 3);
                    fetch_cyc.push_back(cyc);
                    exp_pal.push_back(int'(idx_fn(o)));
                end
            end
            if (pal_req_o) begin
                if (exp_pal.size() == 0) check(0, "R7 extra palette request", pal_idx_o, 0);
                else begin
                    int p;
                    p = exp_pal.pop_front();
                    check(pal_idx_o == 8'(p), "R7 palette index", pal_idx_o, p);
                end
            end
            if (pix_valid_o) begin
                if (exp_rgb.size() == 0) check(0, "R7 extra pixel", pix_rgb_o, 0);
                else begin
                    int e, f;
                    e = exp_rgb.pop_front();
                    f = fetch_cyc.pop_front();
                    check(pix_rgb_o == 24'(e), "R4 R5 pixel colour", pix_rgb_o, e);
                    check(cyc - f == PAL_LAT + 2, "R7 pixel latency", cyc - f, PAL_LAT + 2);
                    if (exp_last.pop_front() != 0) done_exp = 1;
                end
            end
            en_prev = enable_i;
        end
    end

    task automatic plan(int w, int h, bit io);
        for (int y = 0; y < h; y++) begin
            for (int x = 0; x < w; x++) begin
                int o;
                logic [31:0] c;
                o = y * 1024 + x;
                c = ctl_fn(o);
                exp_ofs.push_back(o);
                exp_io.push_back(int'(io));
                exp_last.push_back((x == w - 1 && y == h - 1) ? 1 : 0);
                if (!io && c[31:24] == 8'h03) exp_rgb.push_back(int'(dir_fn(o) & 32'h00FF_FFFF));
                else exp_rgb.push_back(int'(pal_fn(idx_fn(o))));
            end
        end
    endtask

    task automatic go(int w, int h, bit io);
        plan(w, h, io);
        width_i = 11'(w);
        height_i = 10'(h);
        index_only_i = io;
        start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
    endtask

    // Waits until done_o is seen just after an edge; stall pattern and a busy-time start are optional.
    task automatic wait_done(bit stall, bit poke);
        int n = 0;
        while (!done_o) begin
            enable_i = stall ? (n % 3 != 1) : 1'b1;
            start_i = poke && (n == 4);
            if (poke && n == 4) width_i = 11'd7;
            @(posedge clk); #1;
            n++;
        end
        start_i = 1'b0;
        enable_i = 1'b1;
    endtask

    always @(posedge clk) begin
        if (cyc > 100000 && !finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        enable_i = 1'b1;
        @(posedge clk); #1;
        // R4 R5: normal mode, mixed codes, continuous enable
        go(5, 3, 0);
        wait_done(0, 0);
        // R1 R2: stalls plus a start pulse with a different width mid-frame
        go(4, 2, 0);
        wait_done(1, 1);
        // R6: index-only, then R8 start exactly in the done cycle
        go(3, 2, 1);
        wait_done(0, 0);
        go(1024, 2, 0);
        check(busy_o, "R8 restart in done cycle", busy_o, 1);
        wait_done(0, 0);
        // R3: tallest frame, one column
        go(1, 768, 0);
        wait_done(1, 0);
        repeat (8) @(posedge clk);
        #1;
        check(exp_rgb.size() == 0 && exp_ofs.size() == 0, "R7 pixel count", exp_rgb.size(), 0);
        check(!busy_o, "R8 idle at end", busy_o, 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule